// File: doc/BRIEF.md
# CPU Exception Entry and Return Sequencer

This block is the trap sequencer of a small 32-bit RISC core. Each cycle it takes single-cycle event requests from the pipeline (breakpoint, data bus fault, zero divisor, system call) along with the PC of the current instruction. It also has an internal interrupt condition that it forms from its own pending and mask registers. When it accepts an event, it registers a redirect to the handler vector. In the same cycle it writes the faulting PC into one of two link registers: r30 for ordinary exceptions and r31 for breakpoints.

The block keeps a 3-bit interrupt-enable word that works as a small save stack. Bit 0 is the live enable. Bit 1 holds the enable saved by an ordinary exception. Bit 2 holds the enable saved by a breakpoint. A return branch through r30 or r31 pops the matching slot back into bit 0.

The block also holds the software-visible trap registers:
- the enable word;
- the interrupt mask;
- the interrupt pending word, which is set by the interrupt lines and cleared by writing 1s;
- the two handler base addresses, one for ordinary exceptions and one for debug events.

Top module: `trap_sequencer`

## Requirements
- R1: After reset the enable word, the mask and the pending word are 0. Both base registers hold RESET_VEC with its low 8 bits cleared. No redirect is issued.
- R2: An event accepted at clock edge N gives trap_valid high for the one cycle after edge N. In that cycle trap_pc equals base + ID*32. The IDs are: breakpoint 1, data bus fault 4, zero divisor 5, interrupt 6, system call 7.
- R3: With each redirect, link_addr is 30 for an ordinary event and 31 for a breakpoint. link_data holds the pc_i value sampled at the accepting edge.
- R4: Entry to an ordinary event sets the enable word to {0, old bit 0, 0}. Its vector uses the exception base register.
- R5: Entry to a breakpoint sets the enable word to {old bit 0, 0, 0}. Its vector uses the debug base register.
- R6: A return through register 30 sets the enable word to {0, 0, old bit 1}. A return through register 31 sets it to {0, 0, old bit 2}. A return through any other register leaves it unchanged.
- R7: CSR writes use these selectors: enable 0, mask 1, pending 2, exception base 3, debug base 4. A pending write clears each bit written as 1 and keeps each bit written as 0. Every other CSR stores the written value directly. The base registers always read their low 8 bits as 0.
- R8: When several events arrive in the same cycle, only the lowest ID is taken. The order from highest priority is breakpoint, data bus fault, zero divisor, interrupt, system call.
- R9: An interrupt is taken only while enable bit 0 is 1 and (pending AND mask) is nonzero.
- R10: An interrupt line that is high at an edge sets its pending bit. This holds even if a clearing write hits that bit at the same edge.
- R11: When an event entry and a return or an enable write fall at the same edge, the entry update of the enable word wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | PC of the current instruction |
| req_brk | input | 1 | Breakpoint request |
| req_dbus | input | 1 | Data bus fault request (unmapped or misaligned) |
| req_divz | input | 1 | Zero-divisor request |
| req_scall | input | 1 | System call request |
| irq_lines | input | 8 | Interrupt lines, each setting one pending bit |
| ret_valid | input | 1 | A return branch executes this cycle |
| ret_reg | input | 5 | Register operand of the return branch |
| csr_we | input | 1 | CSR write strobe |
| csr_sel | input | 3 | CSR selector |
| csr_wdata | input | 32 | CSR write data |
| trap_valid | output | 1 | Redirect and link write valid |
| trap_pc | output | 32 | Handler vector address |
| link_addr | output | 5 | Link register index (30 or 31) |
| link_data | output | 32 | Return address to store |
| ie_o | output | 3 | Interrupt-enable word |
| im_o | output | 8 | Interrupt mask |
| ip_o | output | 8 | Interrupt pending word |
| eba_o | output | 32 | Exception base address |
| deba_o | output | 32 | Debug base address |

## Verification
The hardest case is an interrupt that competes with a synchronous event in the same cycle. The interrupt request is not a port. It appears only when the registered pending word, the mask and enable bit 0 all line up. The bench first latches a pending bit while the enable word is 0. It then writes the enable word to 1 at one edge and raises a system call or a zero-divisor request at the very next edge. This places the internal interrupt and the external request on the same arbitration edge. The bench also makes a return coincide with an entry, and a clearing write coincide with an interrupt line, to exercise the enable-word and pending precedence rules.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    EID_RESET = 3'd0,
    EID_BREAK = 3'd1,
    EID_IBUS  = 3'd2,
    EID_WATCH = 3'd3,
    EID_DBUS  = 3'd4,
    EID_DIVZ  = 3'd5,
    EID_IRQ   = 3'd6,
    EID_SCALL = 3'd7
  } exc_id_e;

  typedef enum logic [2:0] {
    CSR_IE   = 3'd0,
    CSR_IM   = 3'd1,
    CSR_IP   = 3'd2,
    CSR_EBA  = 3'd3,
    CSR_DEBA = 3'd4
  } csr_sel_e;

  localparam int NUM_IDS   = 8;
  localparam int SLOT_SH   = 5;
  localparam int BASE_ZERO = 8;
  localparam logic [4:0] LINK_EXC = 5'd30;
  localparam logic [4:0] LINK_DBG = 5'd31;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IDS-1:0] req,
  output logic               take,
  output exc_id_e            id
);
  logic [NUM_IDS-1:0] grant;

  // lowest ID wins: scan from the top so the last hit is the lowest
  always_comb begin
    take  = 1'b0;
    id    = EID_RESET;
    grant = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (req[i]) begin
        take     = 1'b1;
        id       = exc_id_e'(3'(i));
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  p_single_grant_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~req) == '0));
  p_lowest_wins_r8: assert property (@(posedge clk) disable iff (rst)
    take |-> ((req & ~({NUM_IDS{1'b1}} << id)) == '0));
endmodule

// File: rtl/trap_enable_stack.sv
module trap_enable_stack
  import trap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enter_norm,
  input  logic       enter_dbg,
  input  logic       ret_valid,
  input  logic [4:0] ret_reg,
  input  logic       wr_en,
  input  logic [2:0] wr_val,
  output logic [2:0] ie
);
  always_ff @(posedge clk) begin
    if (rst)                                ie <= 3'b000;
    else if (enter_dbg)                     ie <= {ie[0], 2'b00};
    else if (enter_norm)                    ie <= {1'b0, ie[0], 1'b0};
    else if (ret_valid && ret_reg == LINK_EXC) ie <= {2'b00, ie[1]};
    else if (ret_valid && ret_reg == LINK_DBG) ie <= {2'b00, ie[2]};
    else if (wr_en)                         ie <= wr_val;
  end

  p_norm_entry_r4: assert property (@(posedge clk) disable iff (rst)
    enter_norm && !enter_dbg |=> ie == {1'b0, $past(ie[0]), 1'b0});
  p_dbg_entry_r5: assert property (@(posedge clk) disable iff (rst)
    enter_dbg |=> ie == {$past(ie[0]), 2'b00});
  p_ret_other_r6: assert property (@(posedge clk) disable iff (rst)
    ret_valid && ret_reg != LINK_EXC && ret_reg != LINK_DBG &&
    !enter_norm && !enter_dbg && !wr_en |=> $stable(ie));
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ie == 3'b000);
endmodule

// File: rtl/trap_csr_file.sv
module trap_csr_file
  import trap_pkg::*;
#(
  parameter int          NIRQ      = 8,
  parameter int          AW        = 32,
  parameter logic [AW-1:0] RESET_VEC = 32'h1000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  csr_sel_e        sel,
  input  logic [AW-1:0]   wdata,
  input  logic [NIRQ-1:0] irq_lines,
  output logic [NIRQ-1:0] im,
  output logic [NIRQ-1:0] ip,
  output logic [AW-1:0]   eba,
  output logic [AW-1:0]   deba
);
  localparam logic [AW-1:0] BASE_RST = {RESET_VEC[AW-1:BASE_ZERO], {BASE_ZERO{1'b0}}};

  logic [NIRQ-1:0] clr_mask;
  logic [AW-1:0]   base_wr;

  assign clr_mask = (we && sel == CSR_IP) ? wdata[NIRQ-1:0] : '0;
  assign base_wr  = {wdata[AW-1:BASE_ZERO], {BASE_ZERO{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      im   <= '0;
      ip   <= '0;
      eba  <= BASE_RST;
      deba <= BASE_RST;
    end else begin
      ip <= (ip & ~clr_mask) | irq_lines;
      if (we && sel == CSR_IM)   im   <= wdata[NIRQ-1:0];
      if (we && sel == CSR_EBA)  eba  <= base_wr;
      if (we && sel == CSR_DEBA) deba <= base_wr;
    end
  end

  p_ip_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    we && sel == CSR_IP && irq_lines == '0 |=>
      ip == ($past(ip) & ~$past(wdata[NIRQ-1:0])));
  p_ip_set_r10: assert property (@(posedge clk) disable iff (rst)
    irq_lines != '0 |=> (ip & $past(irq_lines)) == $past(irq_lines));
  p_im_store_r7: assert property (@(posedge clk) disable iff (rst)
    we && sel == CSR_IM |=> im == $past(wdata[NIRQ-1:0]));
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
  import trap_pkg::*;
#(
  parameter int            NIRQ      = 8,
  parameter int            AW        = 32,
  parameter logic [AW-1:0] RESET_VEC = 32'h1000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   pc_i,
  input  logic            req_brk,
  input  logic            req_dbus,
  input  logic            req_divz,
  input  logic            req_scall,
  input  logic [NIRQ-1:0] irq_lines,
  input  logic            ret_valid,
  input  logic [4:0]      ret_reg,
  input  logic            csr_we,
  input  logic [2:0]      csr_sel,
  input  logic [AW-1:0]   csr_wdata,
  output logic            trap_valid,
  output logic [AW-1:0]   trap_pc,
  output logic [4:0]      link_addr,
  output logic [AW-1:0]   link_data,
  output logic [2:0]      ie_o,
  output logic [NIRQ-1:0] im_o,
  output logic [NIRQ-1:0] ip_o,
  output logic [AW-1:0]   eba_o,
  output logic [AW-1:0]   deba_o
);
  logic [NUM_IDS-1:0] reqv;
  logic               take;
  exc_id_e            id;
  logic               enter_dbg, enter_norm;
  csr_sel_e           sel;
  logic [AW-1:0]      base;

  assign sel = csr_sel_e'(csr_sel);

  always_comb begin
    reqv           = '0;
    reqv[EID_BREAK] = req_brk;
    reqv[EID_DBUS]  = req_dbus;
    reqv[EID_DIVZ]  = req_divz;
    reqv[EID_IRQ]   = ie_o[0] && ((ip_o & im_o) != '0);
    reqv[EID_SCALL] = req_scall;
  end

  trap_arbiter u_arb (
    .clk  (clk),
    .rst  (rst),
    .req  (reqv),
    .take (take),
    .id   (id)
  );

  assign enter_dbg  = take && (id == EID_BREAK);
  assign enter_norm = take && (id != EID_BREAK);

  trap_enable_stack u_ie (
    .clk        (clk),
    .rst        (rst),
    .enter_norm (enter_norm),
    .enter_dbg  (enter_dbg),
    .ret_valid  (ret_valid),
    .ret_reg    (ret_reg),
    .wr_en      (csr_we && sel == CSR_IE),
    .wr_val     (csr_wdata[2:0]),
    .ie         (ie_o)
  );

  trap_csr_file #(.NIRQ(NIRQ), .AW(AW), .RESET_VEC(RESET_VEC)) u_csr (
    .clk       (clk),
    .rst       (rst),
    .we        (csr_we),
    .sel       (sel),
    .wdata     (csr_wdata),
    .irq_lines (irq_lines),
    .im        (im_o),
    .ip        (ip_o),
    .eba       (eba_o),
    .deba      (deba_o)
  );

  // bases keep the low bits zero, so an OR places the slot offset
  assign base = enter_dbg ? deba_o : eba_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid <= 1'b0;
      trap_pc    <= '0;
      link_addr  <= '0;
      link_data  <= '0;
    end else begin
      trap_valid <= take;
      if (take) begin
        trap_pc   <= base | {{(AW-SLOT_SH-3){1'b0}}, id, {SLOT_SH{1'b0}}};
        link_addr <= enter_dbg ? LINK_DBG : LINK_EXC;
        link_data <= pc_i;
      end
    end
  end

  p_slot_align_r2: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> trap_pc[SLOT_SH-1:0] == '0);
  p_dbg_link_r3: assert property (@(posedge clk) disable iff (rst)
    trap_valid |-> ((link_addr == LINK_DBG) == (trap_pc[7:5] == EID_BREAK)));
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    trap_valid && trap_pc[7:5] == EID_IRQ |-> $past(ie_o[0]));
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !trap_valid);
endmodule

// File: tb/tb_trap_sequencer.sv
module tb_trap_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_BASE = 32'h1000_0000;
  localparam logic [31:0] EBA = 32'h2000_0000;
  localparam logic [31:0] DEBA = 32'h3000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i = '0;
  logic        req_brk = 0, req_dbus = 0, req_divz = 0, req_scall = 0;
  logic [7:0]  irq_lines = '0;
  logic        ret_valid = 0;
  logic [4:0]  ret_reg = '0;
  logic        csr_we = 0;
  logic [2:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;
  logic        trap_valid;
  logic [31:0] trap_pc, link_data, eba_o, deba_o;
  logic [4:0]  link_addr;
  logic [2:0]  ie_o;
  logic [7:0]  im_o, ip_o;

  int checks = 0;
  int failures = 0;

  typedef struct packed {
    logic [31:0] vec;
    logic [4:0]  link;
    logic [31:0] data;
  } exp_t;
  exp_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_sequencer dut (
    .clk(clk), .rst(rst), .pc_i(pc_i), .req_brk(req_brk), .req_dbus(req_dbus),
    .req_divz(req_divz), .req_scall(req_scall), .irq_lines(irq_lines),
    .ret_valid(ret_valid), .ret_reg(ret_reg), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .trap_valid(trap_valid), .trap_pc(trap_pc),
    .link_addr(link_addr), .link_data(link_data), .ie_o(ie_o), .im_o(im_o),
    .ip_o(ip_o), .eba_o(eba_o), .deba_o(deba_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: every redirect must match the head of the expectation queue
  always @(negedge clk) begin
    if (!rst && trap_valid) begin
      checks++;
      if (expq.size() == 0) begin
        failures++;
        $display("FAIL R2 unexpected redirect actual=%h expected=none", trap_pc);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (trap_pc !== e.vec || link_addr !== e.link || link_data !== e.data) begin
          failures++;
          $display("FAIL R2/R3 actual=%h/%0d/%h expected=%h/%0d/%h",
                   trap_pc, link_addr, link_data, e.vec, e.link, e.data);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic csr_wr(input logic [2:0] s, input logic [31:0] d);
    csr_we = 1; csr_sel = s; csr_wdata = d;
    tick();
    csr_we = 0;
  endtask

  task automatic ret(input logic [4:0] r);
    ret_valid = 1; ret_reg = r;
    tick();
    ret_valid = 0;
  endtask

  // driver: pushes the expected redirect, then applies the requests for one edge
  task automatic fire(input logic b, input logic d, input logic z, input logic s,
                      input logic [31:0] pc, input logic [31:0] vec, input logic [4:0] lk);
    exp_t e;
    e.vec = vec; e.link = lk; e.data = pc;
    expq.push_back(e);
    pc_i = pc; req_brk = b; req_dbus = d; req_divz = z; req_scall = s;
    tick();
    req_brk = 0; req_dbus = 0; req_divz = 0; req_scall = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ie", {29'd0, ie_o}, 0);
    chk("R1 ip", {24'd0, ip_o}, 0);
    chk("R1 im", {24'd0, im_o}, 0);
    chk("R1 eba", eba_o, RST_BASE);
    chk("R1 deba", deba_o, RST_BASE);
    chk("R1 no redirect", {31'd0, trap_valid}, 0);

    // R7 base writes drop low 8 bits
    csr_wr(3'd3, 32'h2000_0055);
    csr_wr(3'd4, 32'h3000_00FF);
    chk("R7 eba", eba_o, EBA);
    chk("R7 deba", deba_o, DEBA);
    csr_wr(3'd0, 32'h1);
    chk("R7 ie write", {29'd0, ie_o}, 1);

    // R2 R3 R4 zero divisor
    fire(0, 0, 1, 0, 32'h100, EBA + 5*32, 5'd30);
    chk("R4 ie after divz", {29'd0, ie_o}, 3'b010);
    ret(5'd30);
    chk("R6 ret r30", {29'd0, ie_o}, 3'b001);

    // R5 breakpoint off the debug base
    fire(1, 0, 0, 0, 32'h204, DEBA + 1*32, 5'd31);
    chk("R5 ie after brk", {29'd0, ie_o}, 3'b100);
    ret(5'd31);
    chk("R6 ret r31", {29'd0, ie_o}, 3'b001);
    ret(5'd5);
    chk("R6 ret other", {29'd0, ie_o}, 3'b001);

    fire(0, 0, 0, 1, 32'h300, EBA + 7*32, 5'd30);
    chk("R4 ie after scall", {29'd0, ie_o}, 3'b010);
    ret(5'd30);
    fire(0, 1, 0, 0, 32'h308, EBA + 4*32, 5'd30);
    ret(5'd30);

    // R8 priority among simultaneous requests
    fire(1, 1, 1, 1, 32'h400, DEBA + 1*32, 5'd31);
    ret(5'd31);
    fire(0, 1, 1, 1, 32'h404, EBA + 4*32, 5'd30);
    ret(5'd30);
    fire(0, 0, 1, 1, 32'h408, EBA + 5*32, 5'd30);
    ret(5'd30);
    chk("R8 ie restored", {29'd0, ie_o}, 3'b001);

    // R9 masked line does not interrupt; R7 write-1-to-clear
    csr_wr(3'd1, 32'h03);
    chk("R7 im", {24'd0, im_o}, 8'h03);
    irq_lines = 8'h10; tick(); irq_lines = 0;
    tick();
    chk("R9 masked pending", {24'd0, ip_o}, 8'h10);
    csr_wr(3'd2, 32'h00);
    chk("R7 w1c zero keeps", {24'd0, ip_o}, 8'h10);
    csr_wr(3'd2, 32'h10);
    chk("R7 w1c clears", {24'd0, ip_o}, 8'h00);

    // R9 enabled interrupt taken one edge after pending latches
    pc_i = 32'h500;
    begin
      exp_t e;
      e.vec = EBA + 6*32; e.link = 5'd30; e.data = 32'h500;
      expq.push_back(e);
    end
    irq_lines = 8'h02; tick(); irq_lines = 0;
    tick();
    chk("R9 ie after irq", {29'd0, ie_o}, 3'b010);
    tick();
    csr_wr(3'd2, 32'h02);
    ret(5'd30);

    // R9 enable off blocks interrupt
    csr_wr(3'd0, 32'h0);
    irq_lines = 8'h01; tick(); irq_lines = 0;
    tick(); tick();
    chk("R9 blocked no redirect", {31'd0, trap_valid}, 0);
    chk("R9 blocked pending", {24'd0, ip_o}, 8'h01);

    // R8 interrupt beats system call
    csr_wr(3'd0, 32'h1);
    fire(0, 0, 0, 1, 32'h600, EBA + 6*32, 5'd30);
    csr_wr(3'd2, 32'h01);
    ret(5'd30);

    // R8 zero divisor beats interrupt
    csr_wr(3'd0, 32'h0);
    irq_lines = 8'h01; tick(); irq_lines = 0;
    csr_wr(3'd0, 32'h1);
    fire(0, 0, 1, 0, 32'h604, EBA + 5*32, 5'd30);
    csr_wr(3'd2, 32'h01);
    ret(5'd30);
    chk("R8 ie after divz over irq", {29'd0, ie_o}, 3'b001);

    // R10 line high while clearing the same bit
    irq_lines = 8'h04;
    csr_wr(3'd2, 32'h04);
    irq_lines = 0;
    chk("R10 set beats clear", {24'd0, ip_o}, 8'h04);
    csr_wr(3'd2, 32'h04);

    // R11 entry wins over a return at the same edge
    ret_valid = 1; ret_reg = 5'd30;
    fire(0, 0, 1, 0, 32'h700, EBA + 5*32, 5'd30);
    ret_valid = 0;
    chk("R11 entry over return", {29'd0, ie_o}, 3'b010);
    ret(5'd30);

    tick(); tick();
    chk("R2 queue drained", expq.size(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule